// File: doc/BRIEF.md
# NAND Chunk Hamming Parity Generator

This block watches a byte stream moving to or from a NAND device and builds single-error-correcting Hamming parity over every 256-byte chunk, whichever direction the data flows. Each accepted byte updates a running column accumulator (the XOR of all bytes) and a running line accumulator (the byte's overall parity folded into pairs selected by the byte's offset inside the chunk). When the 256th byte of a chunk has been taken, the block publishes a 32-bit parity word, tags it with the chunk's position in the page, and starts the next chunk from a clean state on its own.

Alongside the parity word it derives the 24-bit code that is written to the spare area: the word moved up two places, inverted and cut to 24 bits. That code is also sent out as three bytes, most significant first, so a spare-area writer can take them one per cycle. A clear strobe discards a partly accumulated chunk before a new transfer; an enable input gates accumulation so bytes moved while parity is off leave no trace. Pages of up to sixteen chunks (4096 bytes) are tracked.

Top module: `nand_hamming_ecc`

## Requirements
- R1: After reset, par_word is 0, par_done and code_byte_valid are 0 and par_chunk is 0.
- R2: Bits 5:0 of par_word are column parity over the 256 bytes of a chunk: bit 2k is the XOR of all data bits whose bit index (0..7) has bit k clear, bit 2k+1 the XOR of those whose bit index has bit k set, for k = 0, 1, 2.
- R3: Bits 21:6 of par_word are line parity: bit 6+2j is the XOR of all bits of the bytes whose offset in the chunk (0..255) has bit j clear, bit 7+2j the same for offsets with bit j set, for j = 0..7; bits 31:22 are 0.
- R4: par_done is high for exactly one cycle, the cycle after the edge that accepts the 256th byte of a chunk, and par_word holds its value in every cycle in which par_done is low.
- R5: After a chunk completes, the next chunk's parity starts from zero with no influence from earlier chunks.
- R6: A byte is accepted only in a cycle where in_valid and ecc_en are both 1; other cycles change neither the parity nor the byte count.
- R7: A cycle with ecc_clr high discards the partial chunk (including any byte offered in that same cycle), restarts the byte count and resets the chunk tag to 0.
- R8: code_word equals bits 23:0 of the bitwise inverse of par_word shifted left by two, so bits 1:0 are 1 and bits 23:2 are the inverse of par_word bits 21:0.
- R9: code_byte_valid is high in the par_done cycle and the two cycles after it, with code_byte carrying code bits 23:16, then 15:8, then 7:0; it is low otherwise.
- R10: par_chunk gives the position of the completed chunk in the page, counting 0 to 15 and wrapping to 0 after 16 chunks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ecc_en | input | 1 | Parity accumulation enable |
| ecc_clr | input | 1 | Strobe that discards the partial chunk and restarts the page |
| in_valid | input | 1 | in_byte carries a data byte this cycle |
| in_byte | input | 8 | Data byte |
| par_word | output | 32 | Parity word of the last completed chunk |
| par_done | output | 1 | One-cycle pulse when par_word is new |
| par_chunk | output | 4 | Chunk position of par_word in the page |
| code_word | output | 24 | Spare-area form of par_word |
| code_byte_valid | output | 1 | code_byte carries a spare-area byte |
| code_byte | output | 8 | Spare-area byte, highest first |

## Verification
Chunks are fed with all-zero, all-ones, alternating, ramp and pseudo-random data, plus single set bits at the first offset, the last offset and a middle offset: the empty chunk pins the inverted code, the single bits separate each pair of column and line parity bits so a swapped or misplaced pair is exposed, and dense data catches a wrong fold of byte parity. Some chunks are interleaved with idle cycles and with bytes offered while parity is disabled, which must leave the result identical to an uninterrupted chunk. A clear strobe arriving mid-chunk together with a byte shows the partial data and the chunk tag are dropped, and a run of seventeen chunks walks the tag across its wrap.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    localparam int BYTE_W      = 8;
    localparam int CHUNK_BYTES = 256;
    localparam int OFS_W       = $clog2(CHUNK_BYTES);
    localparam int LINE_W      = 2 * OFS_W;
    localparam int BIT_IDX_W   = $clog2(BYTE_W);
    localparam int COL_W       = 2 * BIT_IDX_W;
    localparam int WORD_W      = 32;
    localparam int CODE_W      = 24;
    localparam int CODE_BYTES  = CODE_W / BYTE_W;
    localparam int CODE_SHIFT  = 2;
    localparam int EMIT_W      = $clog2(CODE_BYTES + 1);

    // Running state of one chunk: byte offset, column XOR, paired line parity.
    typedef struct packed {
        logic [OFS_W-1:0]  cnt;
        logic [BYTE_W-1:0] col;
        logic [LINE_W-1:0] line;
    } acc_t;

    // Pair the column XOR by bit-index bits, place line parity above it.
    function automatic logic [WORD_W-1:0] fold_word(input logic [BYTE_W-1:0] col,
                                                   input logic [LINE_W-1:0] line);
        logic [COL_W-1:0]  cp;
        logic [WORD_W-1:0] w;
        cp = '0;
        for (int k = 0; k < BIT_IDX_W; k++) begin
            for (int b = 0; b < BYTE_W; b++) begin
                if (((b >> k) & 1) != 0) cp[2*k+1] = cp[2*k+1] ^ col[b];
                else                     cp[2*k]   = cp[2*k]   ^ col[b];
            end
        end
        w = '0;
        w[COL_W +: LINE_W] = line;
        w[COL_W-1:0]       = cp;
        return w;
    endfunction

    // Spare-area form: shift up, invert, keep the low CODE_W bits.
    function automatic logic [CODE_W-1:0] to_code(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] s;
        s = ~(w << CODE_SHIFT);
        return s[CODE_W-1:0];
    endfunction

endpackage

// File: rtl/ecc_accum.sv
module ecc_accum
    import nand_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_en,
    input  logic              ecc_clr,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              finish,
    output logic [BYTE_W-1:0] fin_col,
    output logic [LINE_W-1:0] fin_line
);

    acc_t acc_d, acc_q;
    logic take;
    logic row_par;
    logic [LINE_W-1:0] line_upd;

    always_comb begin
        take     = in_valid && ecc_en;
        row_par  = ^in_byte;
        line_upd = acc_q.line;
        for (int j = 0; j < OFS_W; j++) begin
            if (row_par) begin
                if (acc_q.cnt[j]) line_upd[2*j+1] = ~line_upd[2*j+1];
                else              line_upd[2*j]   = ~line_upd[2*j];
            end
        end
        fin_col  = acc_q.col ^ in_byte;
        fin_line = line_upd;
        finish   = 1'b0;
        acc_d    = acc_q;
        if (ecc_clr) begin
            acc_d = '0;
        end else if (take) begin
            if (acc_q.cnt == OFS_W'(CHUNK_BYTES - 1)) begin
                finish = 1'b1;
                acc_d  = '0;
            end else begin
                acc_d.cnt  = acc_q.cnt + 1'b1;
                acc_d.col  = fin_col;
                acc_d.line = line_upd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_clr |=> (acc_q.cnt == '0 && acc_q.col == '0 && acc_q.line == '0)); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ecc_clr && !(in_valid && ecc_en)) |=> $stable(acc_q)); // R6

endmodule

// File: rtl/ecc_result.sv
module ecc_result
    import nand_ecc_pkg::*;
#(
    parameter int MAX_CHUNKS = 16,
    localparam int TAG_W = $clog2(MAX_CHUNKS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_clr,
    input  logic              finish,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] par_word,
    output logic              par_done,
    output logic [TAG_W-1:0]  par_chunk
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              done;
        logic [TAG_W-1:0]  tag;
        logic [TAG_W-1:0]  next_tag;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d      = res_q;
        res_d.done = finish;
        if (ecc_clr) begin
            res_d.next_tag = '0;
        end else if (finish) begin
            res_d.word = word_in;
            res_d.tag  = res_q.next_tag;
            if (res_q.next_tag == TAG_W'(MAX_CHUNKS - 1)) res_d.next_tag = '0;
            else                                         res_d.next_tag = res_q.next_tag + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign par_word  = res_q.word;
    assign par_done  = res_q.done;
    assign par_chunk = res_q.tag;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_q.done |=> !res_q.done); // R4
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_q.done |-> $stable(res_q.word)); // R4

endmodule

// File: rtl/ecc_emit.sv
module ecc_emit
    import nand_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_out
);

    typedef struct packed {
        logic [CODE_W-1:0] sh;
        logic [EMIT_W-1:0] left;
    } emit_t;

    emit_t em_d, em_q;

    always_comb begin
        em_d = em_q;
        if (load) begin
            em_d.sh   = code_in;
            em_d.left = EMIT_W'(CODE_BYTES);
        end else if (em_q.left != '0) begin
            em_d.sh   = em_q.sh << BYTE_W;
            em_d.left = em_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) em_q <= '0;
        else        em_q <= em_d;
    end

    assign byte_valid = (em_q.left != '0);
    assign byte_out   = em_q.sh[CODE_W-1 -: BYTE_W];

    AST_EMIT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> byte_valid); // R9
    AST_EMIT_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && em_q.left > 1) |=> byte_valid); // R9

endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc
    import nand_ecc_pkg::*;
#(
    parameter int MAX_CHUNKS = 16,
    localparam int TAG_W = $clog2(MAX_CHUNKS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_en,
    input  logic              ecc_clr,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic [31:0]       par_word,
    output logic              par_done,
    output logic [TAG_W-1:0]  par_chunk,
    output logic [23:0]       code_word,
    output logic              code_byte_valid,
    output logic [7:0]        code_byte
);

    logic              finish;
    logic [BYTE_W-1:0] fin_col;
    logic [LINE_W-1:0] fin_line;
    logic [WORD_W-1:0] word_next;
    logic [CODE_W-1:0] code_next;

    ecc_accum u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .ecc_en   (ecc_en),
        .ecc_clr  (ecc_clr),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .finish   (finish),
        .fin_col  (fin_col),
        .fin_line (fin_line)
    );

    always_comb begin
        word_next = fold_word(fin_col, fin_line);
        code_next = to_code(word_next);
    end

    ecc_result #(.MAX_CHUNKS(MAX_CHUNKS)) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .ecc_clr   (ecc_clr),
        .finish    (finish),
        .word_in   (word_next),
        .par_word  (par_word),
        .par_done  (par_done),
        .par_chunk (par_chunk)
    );

    ecc_emit u_emit (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (finish),
        .code_in    (code_next),
        .byte_valid (code_byte_valid),
        .byte_out   (code_byte)
    );

    assign code_word = to_code(par_word);

    AST_FIRST_BYTE_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        par_done |-> (code_byte_valid && code_byte == code_word[23:16])); // R9
    AST_CODE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        par_done |-> (par_word[31:22] == '0)); // R3

endmodule

// File: tb/nand_hamming_ecc_bench.sv
`timescale 1ns/1ps
module nand_hamming_ecc_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ecc_en = 1'b0;
    logic        ecc_clr = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic [31:0] par_word;
    logic        par_done;
    logic [3:0]  par_chunk;
    logic [23:0] code_word;
    logic        code_byte_valid;
    logic [7:0]  code_byte;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] chunk_m [256];
    int exp_tag = 0;

    always #2.5 clk = ~clk;

    nand_hamming_ecc u_nand_hamming_ecc (
        .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .ecc_clr(ecc_clr),
        .in_valid(in_valid), .in_byte(in_byte), .par_word(par_word),
        .par_done(par_done), .par_chunk(par_chunk), .code_word(code_word),
        .code_byte_valid(code_byte_valid), .code_byte(code_byte)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat_byte(input int pat, input int i);
        case (pat)
            0: return 8'h00;
            1: return (i == 0) ? 8'h01 : 8'h00;
            2: return (i == 255) ? 8'h80 : 8'h00;
            3: return 8'hFF;
            4: return 8'(i);
            5: return 8'((i * 37 + 11) ^ (i >> 3) ^ (i * i));
            6: return 8'h55;
            7: return (i == 8'h5A) ? 8'h08 : 8'h00;
            default: return 8'((i * 13) ^ pat);
        endcase
    endfunction

    function automatic logic [31:0] model_word();
        logic [7:0]  col;
        logic [5:0]  cp;
        logic [15:0] ln;
        col = '0; ln = '0; cp = '0;
        for (int i = 0; i < 256; i++) begin
            col = col ^ chunk_m[i];
            if (^chunk_m[i]) begin
                for (int j = 0; j < 8; j++) begin
                    if (((i >> j) & 1) != 0) ln[2*j+1] = ~ln[2*j+1];
                    else                     ln[2*j]   = ~ln[2*j];
                end
            end
        end
        for (int k = 0; k < 3; k++)
            for (int b = 0; b < 8; b++)
                if (((b >> k) & 1) != 0) cp[2*k+1] = cp[2*k+1] ^ col[b];
                else                     cp[2*k]   = cp[2*k]   ^ col[b];
        return {10'b0, ln, cp};
    endfunction

    // Feed one chunk; optionally interleave idle cycles and disabled bytes (R6).
    task automatic run_chunk(input int pat, input bit gaps);
        logic [31:0] ew;
        logic [31:0] ec;
        for (int i = 0; i < 256; i++) chunk_m[i] = pat_byte(pat, i);
        ew = model_word();
        ec = {8'h00, ~(ew[21:0]), 2'b11};
        for (int i = 0; i < 256; i++) begin
            if (gaps && (i % 7 == 3)) begin
                @(negedge clk); in_valid = 1'b1; ecc_en = 1'b0; in_byte = ~chunk_m[i];
                @(negedge clk); in_valid = 1'b0; ecc_en = 1'b1; in_byte = 8'hC3;
            end
            @(negedge clk); in_valid = 1'b1; ecc_en = 1'b1; in_byte = chunk_m[i];
        end
        @(negedge clk); in_valid = 1'b0;
        chk("R4 done pulse", {31'b0, par_done}, 32'd1);
        chk("R2 R3 R5 R6 parity word", par_word, ew);
        chk("R8 code word", {8'h00, code_word}, ec);
        chk("R10 chunk tag", {28'b0, par_chunk}, 32'(exp_tag));
        chk("R9 byte hi", {23'b0, code_byte_valid, code_byte}, {23'b0, 1'b1, ec[23:16]});
        @(negedge clk);
        chk("R4 done drops", {31'b0, par_done}, 32'd0);
        chk("R4 word held", par_word, ew);
        chk("R9 byte mid", {23'b0, code_byte_valid, code_byte}, {23'b0, 1'b1, ec[15:8]});
        @(negedge clk);
        chk("R9 byte lo", {23'b0, code_byte_valid, code_byte}, {23'b0, 1'b1, ec[7:0]});
        @(negedge clk);
        chk("R9 emission ends", {31'b0, code_byte_valid}, 32'd0);
        exp_tag = (exp_tag + 1) % 16;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset word", par_word, 32'd0);
        chk("R1 reset done", {30'b0, par_done, code_byte_valid}, 32'd0);
        chk("R1 reset tag", {28'b0, par_chunk}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // Patterns through consecutive chunks (R2, R3, R5)
        for (int p = 0; p < 9; p++) run_chunk(p, p[0]);
        // Partial chunk then clear with a byte in the same cycle (R7)
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); in_valid = 1'b1; ecc_en = 1'b1; in_byte = 8'(i * 7 + 1);
        end
        @(negedge clk); ecc_clr = 1'b1; in_byte = 8'hA7;
        @(negedge clk); ecc_clr = 1'b0; in_valid = 1'b0;
        chk("R7 no completion on clear", {31'b0, par_done}, 32'd0);
        exp_tag = 0;
        run_chunk(5, 1'b0);
        // Walk the tag across its wrap (R10)
        for (int c = 0; c < 16; c++) run_chunk(10 + c, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule